// File: doc/BRIEF.md
# Cache Line Refresh Policy Engine

This block decides the fate of one dynamic-memory cache line each time a refresh request names it. It holds, for every line, a valid flag, a dirty flag and a small idle counter. A refresh request carries a line index. The block reads that line's state, applies the selected data policy and issues one command: refresh the line, write it back, invalidate it, or do nothing. It writes the updated state back to its store in the same step.

Normal read and write accesses also go through the block. They mark a line as valid and, for writes, as dirty. They also reload the idle counter. The idle counter lets a line that is not being used leave the refresh set. A dirty line survives `n` idle refreshes and is then written back. A clean line survives `m` idle refreshes and is then invalidated. The block does not move data itself and does not schedule phases. The caller acts on the commands it issues.

Top module: `rfp_engine`

## Requirements
- R1: After synchronous reset, `cmd_valid` is 0, `cmd_kind` is 0 (none), and every line is invalid with a clear dirty flag and a zero counter.
- R2: A refresh request to an invalid line yields command kind 0 (none) under every policy, and the line's state does not change.
- R3: Under policy 0 (all lines) and policy 1 (valid lines), a valid line gets kind 1 (refresh), and its dirty flag and counter are unchanged.
- R4: Under policy 2 (dirty lines), a valid dirty line gets kind 1 (refresh). A valid clean line gets kind 3 (invalidate) and becomes invalid.
- R5: Under policy 3 (idle writeback), a valid line whose counter is at least 1 gets kind 1 (refresh), and its counter drops by one.
- R6: Under policy 3, a valid dirty line with a zero counter gets kind 2 (writeback). It then becomes valid and clean, with its counter loaded from `idle_m`.
- R7: Under policy 3, a valid clean line with a zero counter gets kind 3 (invalidate) and becomes invalid.
- R8: An accepted access makes the line valid. A write sets the dirty flag, and a read keeps the dirty flag as it was. The counter is loaded with `idle_n` if the line is dirty afterwards, and with `idle_m` otherwise. Values up to 32 are held exactly.
- R9: Each refresh request gives exactly one result in the next cycle. In that cycle `cmd_valid` is 1, `cmd_idx` is the request's index, and `st_valid`, `st_dirty` and `st_count` show the line's state after the update. In a cycle after one with no request, `cmd_valid` is 0 and `cmd_kind` is 0.
- R10: An access in the same cycle as a refresh request is ignored and leaves its line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_req | input | 1 | Refresh request for one line |
| ref_idx | input | IDX_W | Line index of the refresh request |
| policy | input | 2 | Data policy: 0 all, 1 valid, 2 dirty, 3 idle writeback |
| idle_n | input | CNT_W | Idle refreshes a dirty line survives |
| idle_m | input | CNT_W | Idle refreshes a clean line survives |
| acc_en | input | 1 | Normal access to a line |
| acc_idx | input | IDX_W | Line index of the access |
| acc_wr | input | 1 | Access is a write |
| cmd_valid | output | 1 | A result for last cycle's request is present |
| cmd_kind | output | 2 | Command: 0 none, 1 refresh, 2 writeback, 3 invalidate |
| cmd_idx | output | IDX_W | Line the command applies to |
| st_valid | output | 1 | Line valid flag after the update |
| st_dirty | output | 1 | Line dirty flag after the update |
| st_count | output | CNT_W | Line idle counter after the update |

## Verification
A wrong stored flag or counter inside the store shows up at the ports the first time that line is named by a refresh request. It appears one cycle after the request, either in `cmd_kind` or in the `st_*` fields. A counter that is off by one shows up later. It is exposed when the idle-writeback countdown ends one refresh early or late, so the bench walks whole countdowns and compares every cycle against a behavioural model. The bench reads line state through all-lines refresh requests, which leave the state unchanged. This brings out, at the ports, the effect of accesses and of accesses that should have been dropped.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    // Counter width, sized to hold the largest idle limit (32).
    localparam int CNT_W = 6;

    typedef enum logic [1:0] {
        POL_ALL     = 2'd0,
        POL_VALID   = 2'd1,
        POL_DIRTY   = 2'd2,
        POL_IDLE_WB = 2'd3
    } pol_e;

    typedef enum logic [1:0] {
        CMD_NONE       = 2'd0,
        CMD_REFRESH    = 2'd1,
        CMD_WRITEBACK  = 2'd2,
        CMD_INVALIDATE = 2'd3
    } cmd_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [CNT_W-1:0] count;
    } line_t;

    localparam int LINE_W = $bits(line_t);

    function automatic line_t line_reset();
        line_t l;
        l.valid = 1'b0;
        l.dirty = 1'b0;
        l.count = '0;
        return l;
    endfunction

endpackage

// File: rtl/rfp_line_store.sv
module rfp_line_store
    import rfp_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);

    line_t lines_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines_q[g] <= line_reset();
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                lines_q[g] <= wr_line;
            end
        end
    end

    always_comb begin
        rd_line = line_reset();
        for (int i = 0; i < LINES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_line = lines_q[i];
            end
        end
    end

endmodule

// File: rtl/rfp_decide.sv
module rfp_decide
    import rfp_pkg::*;
(
    input  line_t            cur,
    input  pol_e             pol,
    input  logic [CNT_W-1:0] lim_m,
    output cmd_e             cmd,
    output line_t            nxt
);

    always_comb begin
        cmd = CMD_NONE;
        nxt = cur;
        if (cur.valid) begin
            unique case (pol)
                POL_ALL, POL_VALID: begin
                    cmd = CMD_REFRESH;
                end
                POL_DIRTY: begin
                    if (cur.dirty) begin
                        cmd = CMD_REFRESH;
                    end else begin
                        cmd       = CMD_INVALIDATE;
                        nxt.valid = 1'b0;
                    end
                end
                POL_IDLE_WB: begin
                    if (cur.count != '0) begin
                        cmd       = CMD_REFRESH;
                        nxt.count = cur.count - 1'b1;
                    end else if (cur.dirty) begin
                        cmd       = CMD_WRITEBACK;
                        nxt.dirty = 1'b0;
                        nxt.count = lim_m;
                    end else begin
                        cmd       = CMD_INVALIDATE;
                        nxt.valid = 1'b0;
                    end
                end
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/rfp_access_update.sv
module rfp_access_update
    import rfp_pkg::*;
(
    input  line_t            cur,
    input  logic             is_wr,
    input  logic [CNT_W-1:0] lim_n,
    input  logic [CNT_W-1:0] lim_m,
    output line_t            nxt
);

    always_comb begin
        nxt.valid = 1'b1;
        nxt.dirty = cur.dirty | is_wr;
        nxt.count = nxt.dirty ? lim_n : lim_m;
    end

endmodule

// File: rtl/rfp_engine.sv
module rfp_engine
    import rfp_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ref_req,
    input  logic [IDX_W-1:0]          ref_idx,
    input  logic [1:0]                policy,
    input  logic [rfp_pkg::CNT_W-1:0] idle_n,
    input  logic [rfp_pkg::CNT_W-1:0] idle_m,
    input  logic                      acc_en,
    input  logic [IDX_W-1:0]          acc_idx,
    input  logic                      acc_wr,
    output logic                      cmd_valid,
    output logic [1:0]                cmd_kind,
    output logic [IDX_W-1:0]          cmd_idx,
    output logic                      st_valid,
    output logic                      st_dirty,
    output logic [rfp_pkg::CNT_W-1:0] st_count
);

    line_t            cur_line;
    line_t            ref_next;
    line_t            acc_next;
    line_t            wr_line;
    cmd_e             dec_cmd;
    logic [IDX_W-1:0] sel_idx;
    logic             acc_take;
    logic             wr_en;

    // A refresh request has the single port; an access that collides is dropped.
    assign acc_take = acc_en & ~ref_req;
    assign sel_idx  = ref_req ? ref_idx : acc_idx;
    assign wr_en    = ref_req | acc_take;
    assign wr_line  = ref_req ? ref_next : acc_next;

    rfp_line_store #(.LINES(LINES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (sel_idx),
        .rd_line (cur_line),
        .wr_en   (wr_en),
        .wr_idx  (sel_idx),
        .wr_line (wr_line)
    );

    rfp_decide u_decide (
        .cur   (cur_line),
        .pol   (pol_e'(policy)),
        .lim_m (idle_m),
        .cmd   (dec_cmd),
        .nxt   (ref_next)
    );

    rfp_access_update u_access (
        .cur   (cur_line),
        .is_wr (acc_wr),
        .lim_n (idle_n),
        .lim_m (idle_m),
        .nxt   (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_NONE;
            cmd_idx   <= '0;
            st_valid  <= 1'b0;
            st_dirty  <= 1'b0;
            st_count  <= '0;
        end else if (ref_req) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= dec_cmd;
            cmd_idx   <= ref_idx;
            st_valid  <= ref_next.valid;
            st_dirty  <= ref_next.dirty;
            st_count  <= ref_next.count;
        end else begin
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_NONE;
        end
    end

endmodule

// File: rtl/rfp_engine_chk.sv
module rfp_engine_chk #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_req,
    input logic [1:0]       policy,
    input logic [CNT_W-1:0] idle_m,
    input logic             cmd_valid,
    input logic [1:0]       cmd_kind,
    input logic             st_valid,
    input logic             st_dirty,
    input logic [CNT_W-1:0] st_count
);

    assert_req_answered_R9: assert property (@(posedge clk) disable iff (rst)
        ref_req |=> cmd_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !ref_req |=> (!cmd_valid && cmd_kind == 2'd0));

    assert_none_invalid_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd0) |-> !st_valid);

    assert_refresh_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd1) |-> st_valid);

    assert_inval_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3) |-> (!st_valid && !st_dirty));

    assert_wb_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd2) |-> (st_valid && !st_dirty && st_count == $past(idle_m)));

    assert_keep_modes_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_req && policy[1] == 1'b0) |=> (cmd_kind == 2'd0 || cmd_kind == 2'd1));

endmodule

bind rfp_engine rfp_engine_chk #(.IDX_W(IDX_W), .CNT_W(rfp_pkg::CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_req   (ref_req),
    .policy    (policy),
    .idle_m    (idle_m),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .st_valid  (st_valid),
    .st_dirty  (st_dirty),
    .st_count  (st_count)
);

// File: tb/test_rfp_engine.sv
module test_rfp_engine;

    localparam int LINES = 16;
    localparam int IDX_W = 4;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_req = 1'b0;
    logic [IDX_W-1:0] ref_idx = '0;
    logic [1:0]       policy = '0;
    logic [CNT_W-1:0] idle_n = '0;
    logic [CNT_W-1:0] idle_m = '0;
    logic             acc_en = 1'b0;
    logic [IDX_W-1:0] acc_idx = '0;
    logic             acc_wr = 1'b0;
    logic             cmd_valid;
    logic [1:0]       cmd_kind;
    logic [IDX_W-1:0] cmd_idx;
    logic             st_valid;
    logic             st_dirty;
    logic [CNT_W-1:0] st_count;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int mv [LINES];
    int md [LINES];
    int mc [LINES];

    always #4 clk = ~clk;

    rfp_engine #(.LINES(LINES)) i_rfp_engine (
        .clk(clk), .rst(rst), .ref_req(ref_req), .ref_idx(ref_idx), .policy(policy),
        .idle_n(idle_n), .idle_m(idle_m), .acc_en(acc_en), .acc_idx(acc_idx),
        .acc_wr(acc_wr), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_idx(cmd_idx),
        .st_valid(st_valid), .st_dirty(st_dirty), .st_count(st_count)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, model the result, compare after the rising edge.
    task automatic step(input bit rq, input int ri, input int pol,
                        input bit ae, input int ai, input bit aw, input string tag);
        int ek = 0;
        ref_req = rq; ref_idx = IDX_W'(ri); policy = 2'(pol);
        acc_en = ae; acc_idx = IDX_W'(ai); acc_wr = aw;
        if (rq) begin
            if (mv[ri] != 0) begin
                case (pol)
                    0, 1: ek = 1;
                    2: if (md[ri] != 0) ek = 1; else begin ek = 3; mv[ri] = 0; end
                    default: begin
                        if (mc[ri] > 0) begin ek = 1; mc[ri]--; end
                        else if (md[ri] != 0) begin ek = 2; md[ri] = 0; mc[ri] = int'(idle_m); end
                        else begin ek = 3; mv[ri] = 0; end
                    end
                endcase
            end
        end else if (ae) begin
            mv[ai] = 1;
            if (aw) md[ai] = 1;
            mc[ai] = (md[ai] != 0) ? int'(idle_n) : int'(idle_m);
        end
        @(posedge clk);
        #2;
        if (rq) begin
            check(cmd_valid == 1'b1, tag, "cmd_valid", int'(cmd_valid), 1);
            check(int'(cmd_kind) == ek, tag, "cmd_kind", int'(cmd_kind), ek);
            check(int'(cmd_idx) == ri, tag, "cmd_idx", int'(cmd_idx), ri);
            check(int'(st_valid) == mv[ri], tag, "st_valid", int'(st_valid), mv[ri]);
            check(int'(st_dirty) == md[ri], tag, "st_dirty", int'(st_dirty), md[ri]);
            check(int'(st_count) == mc[ri], tag, "st_count", int'(st_count), mc[ri]);
        end else begin
            check(cmd_valid == 1'b0, tag, "cmd_valid idle", int'(cmd_valid), 0);
            check(cmd_kind == 2'd0, tag, "cmd_kind idle", int'(cmd_kind), 0);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < LINES; i++) begin mv[i] = 0; md[i] = 0; mc[i] = 0; end
        idle_n = 6'd4;
        idle_m = 6'd2;
        repeat (3) @(posedge clk);
        #2;
        check(cmd_valid == 1'b0, "R1", "cmd_valid in reset", int'(cmd_valid), 0);
        check(cmd_kind == 2'd0, "R1", "cmd_kind in reset", int'(cmd_kind), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: every line starts invalid; no mode acts on it.
        for (int p = 0; p < 4; p++) step(1, 3, p, 0, 0, 0, "R2");
        step(1, 9, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R9");

        // R8: accesses fill lines.
        step(0, 0, 0, 1, 1, 1, "R8");
        step(0, 0, 0, 1, 2, 0, "R8");
        step(0, 0, 0, 1, 5, 1, "R8");
        step(1, 1, 0, 0, 0, 0, "R8");
        step(1, 2, 1, 0, 0, 0, "R3");
        step(1, 5, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 1, 0, "R8");
        step(1, 1, 0, 0, 0, 0, "R8");

        // R4: dirty-only policy.
        step(1, 1, 2, 0, 0, 0, "R4");
        step(1, 2, 2, 0, 0, 0, "R4");
        step(1, 2, 2, 0, 0, 0, "R2");

        // R5 / R6 / R7: full idle countdown on line 1.
        for (int k = 0; k < 4; k++) step(1, 1, 3, 0, 0, 0, "R5");
        step(1, 1, 3, 0, 0, 0, "R6");
        for (int k = 0; k < 2; k++) step(1, 1, 3, 0, 0, 0, "R5");
        step(1, 1, 3, 0, 0, 0, "R7");
        step(1, 1, 3, 0, 0, 0, "R2");

        // R10: colliding access is dropped.
        step(1, 5, 0, 1, 6, 1, "R10");
        step(1, 6, 0, 0, 0, 0, "R10");

        // R8 boundary: limit 32 held exactly.
        idle_n = 6'd32;
        idle_m = 6'd32;
        step(0, 0, 0, 1, 7, 1, "R8");
        step(1, 7, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 8, 0, "R8");
        step(1, 8, 1, 0, 0, 0, "R8");

        // R9: mixed traffic compared every cycle.
        idle_n = 6'd3;
        idle_m = 6'd1;
        for (int k = 0; k < 600; k++) begin
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), "R9");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule